// File: doc/BRIEF.md
# OSD Character Pixel Generator

This block draws a text overlay on a monitor picture. It follows the falling edges of the horizontal and vertical sync pulses, counts dot clocks and scan lines, and places a grid of 10 character rows by 24 character cells at a programmable origin. For each cell it looks up a 7-bit character code and a 3-bit foreground color in an internal display memory. A small pattern table turns the code into 12-dot glyph lines. The glyph line is shifted out one dot per clock. The block drives R, G and B, plus a fast-blank signal that tells the external video path to give way while a character dot is shown.

A host fills the display memory through a one-cycle cell write port. Each row has a two-bit size register, set through a separate write port, that selects normal, double-height, double-width or double-both glyphs. Row size is sampled once, when the row's first scan line begins. The code for the next cell is fetched while the current cell is still shifting out, so adjacent characters join without a gap.

Top module: `osd_pixel_gen`

## Requirements
- R1: After reset all outputs are low and every display cell holds code 0 and color 0, so any cell that is never written shows nothing.
- R2: A horizontal sync falling edge (`hsync_ni` sampled high, then low) restarts the dot count and ends any character line in progress. The outputs are low two cycles after that edge. A vertical sync falling edge restarts the scan-line count.
- R3: Let E be the clock edge at which `hsync_ni` is first sampled low, with `h_origin_i` ≥ 1. The dot at horizontal offset x of a character row appears on the outputs just after edge E + `h_origin_i` + 2 + x. A normal row has 24 cells of 12 dots each, sent most significant bit first, with no gap between cells.
- R4: Scan lines are numbered by the count of horizontal falling edges since the last vertical falling edge. The line numbered `v_origin_i` is line 0 of row 0. Rows follow one after another and stop after row 9.
- R5: The glyph line for code c at glyph line l (0..15) is 0 when c = 0. Otherwise it is the 12-bit value {c[6:0], l[3:0], 1}.
- R6: Size bit 0 (double width) holds each dot for two clocks, which makes a cell 24 clocks wide.
- R7: Size bit 1 (double height) shows each glyph line on two scan lines, which makes the row 32 lines tall. Size is taken from the row's register when the row's first line starts.
- R8: `fblank_o` is high exactly while a set glyph dot is shown. On those dots red, green and blue carry cell color bits 2, 1 and 0; at all other times they are low.
- R9: All outputs are low before the horizontal origin, after the 24th cell, above row 0 and below row 9.
- R10: A cell write with row ≥ 10 or column ≥ 24, or a size write with row ≥ 10, changes no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_ni | input | 1 | Horizontal sync, falling edge active |
| vsync_ni | input | 1 | Vertical sync, falling edge active |
| h_origin_i | input | 11 | Dot clocks from horizontal sync to the first cell (≥ 1) |
| v_origin_i | input | 10 | Scan line of row 0 |
| cell_we_i | input | 1 | Cell write strobe |
| cell_row_i | input | 4 | Cell write row |
| cell_col_i | input | 5 | Cell write column |
| cell_code_i | input | 7 | Character code to store |
| cell_color_i | input | 3 | Foreground color {R,G,B} to store |
| size_we_i | input | 1 | Row size write strobe |
| size_row_i | input | 4 | Row size write row |
| size_i | input | 2 | Size: bit 1 double height, bit 0 double width |
| red_o | output | 1 | Red video |
| green_o | output | 1 | Green video |
| blue_o | output | 1 | Blue video |
| fblank_o | output | 1 | Fast blank, high on a shown character dot |

## Verification
The assertions check on every cycle that:
- color never appears without fast blank;
- an hsync falling edge blanks the output two cycles later;
- nothing is shown unless the dot shifter is active;
- the column, row and line-within-row counters stay inside the grid for the current row size.

Other behaviour needs the bench's reference model, which is compared with the outputs on every clock. That covers the exact dot position relative to the origins, the glyph pattern, color routing, the doubled widths and heights in mixed-size rows, cell-to-cell joins, a line cut short by an early sync, and the dropping of out-of-range writes.

// File: rtl/osd_pkg.sv
package osd_pkg;
  localparam int COLS    = 24;
  localparam int ROWS    = 10;
  localparam int DOTS    = 12;
  localparam int LINES   = 16;
  localparam int CODE_W  = 7;
  localparam int COLOR_W = 3;

  localparam int COL_W  = $clog2(COLS + 1);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int DOT_W  = $clog2(DOTS);
  localparam int GL_W   = $clog2(LINES);
  localparam int VL_W   = $clog2(2 * LINES);
  localparam int CELLS  = ROWS * COLS;
  localparam int ADDR_W = $clog2(CELLS + 1);

  typedef struct packed {
    logic [CODE_W-1:0]  code;
    logic [COLOR_W-1:0] color;
  } cell_t;

  typedef struct packed {
    logic dbl_h;
    logic dbl_w;
  } row_size_t;
endpackage

// File: rtl/osd_sync_timer.sv
module osd_sync_timer #(
  parameter int HCNT_W = 11,
  parameter int VCNT_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_ni,
  input  logic              vsync_ni,
  output logic              hfall_o,
  output logic              vfall_o,
  output logic [HCNT_W-1:0] hcnt_o,
  output logic [VCNT_W-1:0] vcnt_o
);
  logic hs_q, vs_q;

  assign hfall_o = hs_q & ~hsync_ni;
  assign vfall_o = vs_q & ~vsync_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q   <= 1'b1;
      vs_q   <= 1'b1;
      hcnt_o <= '0;
      vcnt_o <= '0;
    end else begin
      hs_q <= hsync_ni;
      vs_q <= vsync_ni;
      if (hfall_o)           hcnt_o <= '0;
      else if (~&hcnt_o)     hcnt_o <= hcnt_o + 1'b1;
      if (vfall_o)                  vcnt_o <= '0;
      else if (hfall_o && ~&vcnt_o) vcnt_o <= vcnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/osd_row_tracker.sv
module osd_row_tracker
  import osd_pkg::*;
#(
  parameter int VCNT_W = 10
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         hfall_i,
  input  logic                         vfall_i,
  input  logic [VCNT_W-1:0]            vcnt_i,
  input  logic [VCNT_W-1:0]            v_origin_i,
  input  row_size_t [ROWS-1:0]         sizes_i,
  output logic                         vact_o,
  output logic [ROW_W-1:0]             row_o,
  output logic [VL_W-1:0]              line_o,
  output row_size_t                    size_o,
  output logic [GL_W-1:0]              glyph_line_o
);
  logic              started_q;
  logic              ev;
  logic              start;
  logic [VCNT_W:0]   next_line;
  logic [VL_W-1:0]   last_line;
  logic [ROW_W-1:0]  next_row;

  assign ev        = hfall_i | vfall_i;
  assign next_line = vfall_i ? '0 : {1'b0, vcnt_i} + 1'b1;
  assign start     = ev && (vfall_i || !started_q) && (next_line == {1'b0, v_origin_i});
  assign last_line = size_o.dbl_h ? VL_W'(2 * LINES - 1) : VL_W'(LINES - 1);
  assign next_row  = row_o + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      vact_o    <= 1'b0;
      row_o     <= '0;
      line_o    <= '0;
      size_o    <= '0;
    end else if (ev) begin
      if (start) begin
        started_q <= 1'b1;
        vact_o    <= 1'b1;
        row_o     <= '0;
        line_o    <= '0;
        size_o    <= sizes_i[0];
      end else if (vfall_i) begin
        started_q <= 1'b0;
        vact_o    <= 1'b0;
      end else if (vact_o) begin
        if (line_o == last_line) begin
          line_o <= '0;
          if (row_o == ROW_W'(ROWS - 1)) begin
            vact_o <= 1'b0;
          end else begin
            row_o  <= next_row;
            size_o <= sizes_i[next_row];
          end
        end else begin
          line_o <= line_o + 1'b1;
        end
      end
    end
  end

  assign glyph_line_o = size_o.dbl_h ? line_o[GL_W:1] : line_o[GL_W-1:0];
endmodule

// File: rtl/osd_glyph_rom.sv
module osd_glyph_rom
  import osd_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic [GL_W-1:0]   line_i,
  output logic [DOTS-1:0]   bits_o
);
  // test glyphs: blank for code 0, else code, line index and a trailing set dot
  assign bits_o = (code_i == '0) ? '0 : DOTS'({code_i, line_i, 1'b1});
endmodule

// File: rtl/osd_dot_shifter.sv
module osd_dot_shifter
  import osd_pkg::*;
#(
  parameter int HCNT_W = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hfall_i,
  input  logic [HCNT_W-1:0]  hcnt_i,
  input  logic [HCNT_W-1:0]  h_origin_i,
  input  logic               vact_i,
  input  logic               dbl_w_i,
  input  logic [DOTS-1:0]    glyph_i,
  input  logic [COLOR_W-1:0] next_color_i,
  output logic               active_o,
  output logic [COL_W-1:0]   col_o,
  output logic [COL_W-1:0]   fetch_col_o,
  output logic               pix_o,
  output logic [COLOR_W-1:0] color_o
);
  logic             started_q;
  logic             half_q;
  logic [DOT_W-1:0] dot_q;
  logic [DOTS-1:0]  sr_q;

  assign fetch_col_o = active_o ? col_o + 1'b1 : '0;
  assign pix_o       = active_o & sr_q[DOTS-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      active_o  <= 1'b0;
      half_q    <= 1'b0;
      dot_q     <= '0;
      col_o     <= '0;
      sr_q      <= '0;
      color_o   <= '0;
    end else if (hfall_i) begin
      started_q <= 1'b0;
      active_o  <= 1'b0;
      sr_q      <= '0;
    end else if (!active_o) begin
      if (!started_q && vact_i && hcnt_i == h_origin_i) begin
        started_q <= 1'b1;
        active_o  <= 1'b1;
        half_q    <= 1'b0;
        dot_q     <= '0;
        col_o     <= '0;
        sr_q      <= glyph_i;
        color_o   <= next_color_i;
      end
    end else if (dbl_w_i && !half_q) begin
      half_q <= 1'b1;
    end else begin
      half_q <= 1'b0;
      if (dot_q == DOT_W'(DOTS - 1)) begin
        dot_q <= '0;
        if (col_o == COL_W'(COLS - 1)) begin
          active_o <= 1'b0;
          sr_q     <= '0;
        end else begin
          col_o   <= col_o + 1'b1;
          sr_q    <= glyph_i;
          color_o <= next_color_i;
        end
      end else begin
        dot_q <= dot_q + 1'b1;
        sr_q  <= {sr_q[DOTS-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/osd_pixel_gen.sv
module osd_pixel_gen
  import osd_pkg::*;
#(
  parameter int HCNT_W = 11,
  parameter int VCNT_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hsync_ni,
  input  logic               vsync_ni,
  input  logic [HCNT_W-1:0]  h_origin_i,
  input  logic [VCNT_W-1:0]  v_origin_i,
  input  logic               cell_we_i,
  input  logic [ROW_W-1:0]   cell_row_i,
  input  logic [COL_W-1:0]   cell_col_i,
  input  logic [CODE_W-1:0]  cell_code_i,
  input  logic [COLOR_W-1:0] cell_color_i,
  input  logic               size_we_i,
  input  logic [ROW_W-1:0]   size_row_i,
  input  logic [1:0]         size_i,
  output logic               red_o,
  output logic               green_o,
  output logic               blue_o,
  output logic               fblank_o
);
  localparam logic [ADDR_W-1:0] COLS_A  = ADDR_W'(COLS);
  localparam logic [ADDR_W-1:0] CELLS_A = ADDR_W'(CELLS);

  logic                 hfall, vfall;
  logic [HCNT_W-1:0]    hcnt;
  logic [VCNT_W-1:0]    vcnt;
  logic                 v_act;
  logic [ROW_W-1:0]     v_row;
  logic [VL_W-1:0]      v_line;
  row_size_t            v_size;
  logic [GL_W-1:0]      glyph_line;
  logic                 sh_active;
  logic [COL_W-1:0]     sh_col;
  logic [COL_W-1:0]     fetch_col;
  logic                 pix;
  logic [COLOR_W-1:0]   pix_color;
  logic [DOTS-1:0]      glyph;
  cell_t                mem_q [CELLS];
  row_size_t [ROWS-1:0] sizes_q;
  cell_t                nxt_q;
  logic [ADDR_W-1:0]    wr_addr, rd_addr;
  logic                 wr_ok;

  osd_sync_timer #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W)) i_timer (
    .clk_i, .rst_ni, .hsync_ni, .vsync_ni,
    .hfall_o(hfall), .vfall_o(vfall), .hcnt_o(hcnt), .vcnt_o(vcnt)
  );

  osd_row_tracker #(.VCNT_W(VCNT_W)) i_rows (
    .clk_i, .rst_ni, .hfall_i(hfall), .vfall_i(vfall), .vcnt_i(vcnt),
    .v_origin_i, .sizes_i(sizes_q), .vact_o(v_act), .row_o(v_row),
    .line_o(v_line), .size_o(v_size), .glyph_line_o(glyph_line)
  );

  osd_glyph_rom i_rom (
    .code_i(nxt_q.code), .line_i(glyph_line), .bits_o(glyph)
  );

  osd_dot_shifter #(.HCNT_W(HCNT_W)) i_shift (
    .clk_i, .rst_ni, .hfall_i(hfall), .hcnt_i(hcnt), .h_origin_i,
    .vact_i(v_act), .dbl_w_i(v_size.dbl_w), .glyph_i(glyph),
    .next_color_i(nxt_q.color), .active_o(sh_active), .col_o(sh_col),
    .fetch_col_o(fetch_col), .pix_o(pix), .color_o(pix_color)
  );

  // display memory
  assign wr_ok   = (cell_row_i < ROW_W'(ROWS)) && (cell_col_i < COL_W'(COLS));
  assign wr_addr = ADDR_W'(cell_row_i) * COLS_A + ADDR_W'(cell_col_i);
  assign rd_addr = ADDR_W'(v_row) * COLS_A + ADDR_W'(fetch_col);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CELLS; i++) mem_q[i] <= '0;
    end else if (cell_we_i && wr_ok) begin
      mem_q[wr_addr] <= '{code: cell_code_i, color: cell_color_i};
    end
  end

  for (genvar g = 0; g < ROWS; g++) begin : g_size
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       sizes_q[g] <= '0;
      else if (size_we_i && size_row_i == ROW_W'(g))     sizes_q[g] <= size_i;
    end
  end

  // next cell prefetched while the current one shifts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                nxt_q <= '0;
    else if (rd_addr < CELLS_A) nxt_q <= mem_q[rd_addr];
    else                        nxt_q <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      red_o    <= 1'b0;
      green_o  <= 1'b0;
      blue_o   <= 1'b0;
      fblank_o <= 1'b0;
    end else begin
      red_o    <= pix & pix_color[2];
      green_o  <= pix & pix_color[1];
      blue_o   <= pix & pix_color[0];
      fblank_o <= pix;
    end
  end
endmodule

// File: rtl/osd_pixel_gen_chk.sv
module osd_pixel_gen_chk
  import osd_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hsync_ni,
  input logic             red_o,
  input logic             green_o,
  input logic             blue_o,
  input logic             fblank_o,
  input logic             sh_active,
  input logic [COL_W-1:0] sh_col,
  input logic             v_act,
  input logic [ROW_W-1:0] v_row,
  input logic [VL_W-1:0]  v_line,
  input logic             dbl_h
);
  a_r8_color_needs_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (red_o || green_o || blue_o) |-> fblank_o);

  a_r2_hsync_blanks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hsync_ni) |=> ##1 !fblank_o);

  a_r9_blank_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sh_active) |-> !fblank_o);

  a_r3_col_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_active |-> sh_col < COL_W'(COLS));

  a_r4_row_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_act |-> v_row < ROW_W'(ROWS));

  a_r7_line_in_pitch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_act && !dbl_h) |-> v_line < VL_W'(LINES));
endmodule

bind osd_pixel_gen osd_pixel_gen_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hsync_ni(hsync_ni),
  .red_o(red_o), .green_o(green_o), .blue_o(blue_o), .fblank_o(fblank_o),
  .sh_active(sh_active), .sh_col(sh_col), .v_act(v_act), .v_row(v_row),
  .v_line(v_line), .dbl_h(v_size.dbl_h)
);

// File: tb/test_osd_pixel_gen.sv
module test_osd_pixel_gen;
  import osd_pkg::*;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic hsync_ni = 1'b1, vsync_ni = 1'b1;
  logic [10:0] h_origin_i = '0;
  logic [9:0]  v_origin_i = '0;
  logic        cell_we_i = 1'b0;
  logic [3:0]  cell_row_i = '0;
  logic [4:0]  cell_col_i = '0;
  logic [6:0]  cell_code_i = '0;
  logic [2:0]  cell_color_i = '0;
  logic        size_we_i = 1'b0;
  logic [3:0]  size_row_i = '0;
  logic [1:0]  size_i = '0;
  logic red_o, green_o, blue_o, fblank_o;

  always #5 clk_i = ~clk_i;

  osd_pixel_gen i_osd_pixel_gen (.*);

  int n_checks = 0, n_fails = 0;
  bit done = 0;

  // reference model state
  int mcode [10][24];
  int mcolor[10][24];
  int msize [10];
  int ed = -1000000, lc = 0;
  logic phs = 1'b1, pvs = 1'b1;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h (ed=%0d lc=%0d)", req, act, exp, ed, lc);
    end
  endtask

  task automatic expect_px(output logic f, output logic [2:0] rgb, output string lab);
    int x, y, r, w, c, d, gl, h, code;
    bit found;
    logic [11:0] bits;
    f = 0; rgb = 0; lab = "R4"; found = 0; r = 0;
    x = ed - int'(h_origin_i) - 2;
    y = lc - int'(v_origin_i);
    if (y < 0) return;
    for (int k = 0; k < 10; k++) begin
      h = msize[k][1] ? 32 : 16;
      if (!found) begin
        if (y < h) begin r = k; found = 1; end
        else y -= h;
      end
    end
    if (!found) return;
    w = msize[r][0] ? 24 : 12;
    lab = "R9";
    if (x < 0 || x >= 24 * w) return;
    c  = x / w;
    d  = (x % w) / (msize[r][0] ? 2 : 1);
    gl = msize[r][1] ? y / 2 : y;
    if (r == 9)                lab = "R1";
    else if (r == 1 && c == 6) lab = "R10";
    else if (msize[r][0])      lab = "R6";
    else if (msize[r][1])      lab = "R7";
    else                       lab = "R3 R5 R8";
    code = mcode[r][c];
    bits = (code == 0) ? 12'h000 : {7'(code), 4'(gl), 1'b1};
    f = bits[11 - d];
    rgb = f ? 3'(mcolor[r][c]) : 3'b000;
  endtask

  task automatic step();
    logic f;
    logic [2:0] rgb;
    string lab;
    bit hf, vf;
    @(posedge clk_i);
    hf = phs & ~hsync_ni;
    vf = pvs & ~vsync_ni;
    phs = hsync_ni;
    pvs = vsync_ni;
    if (hf) ed = 0; else ed++;
    if (vf) lc = 0; else if (hf) lc++;
    @(negedge clk_i);
    expect_px(f, rgb, lab);
    check(lab, {red_o, green_o, blue_o, fblank_o}, {rgb, f});
    if (ed == 1) check("R2", fblank_o, 0);
  endtask

  task automatic frame(input int lines, input int len, input int cut_line, input int cut_len);
    vsync_ni = 1'b0;
    repeat (3) step();
    vsync_ni = 1'b1;
    step();
    for (int ln = 0; ln < lines; ln++) begin
      int l = (ln == cut_line) ? cut_len : len;
      for (int i = 0; i < l; i++) begin
        hsync_ni = (i < 4) ? 1'b0 : 1'b1;
        step();
      end
    end
  endtask

  task automatic put_cell(input int r, input int c, input int code, input int color);
    cell_we_i = 1'b1; cell_row_i = 4'(r); cell_col_i = 5'(c);
    cell_code_i = 7'(code); cell_color_i = 3'(color);
    step();
    cell_we_i = 1'b0;
    if (r < 10 && c < 24) begin mcode[r][c] = code; mcolor[r][c] = color; end
  endtask

  task automatic put_size(input int r, input int s);
    size_we_i = 1'b1; size_row_i = 4'(r); size_i = 2'(s);
    step();
    size_we_i = 1'b0;
    if (r < 10) msize[r] = s;
  endtask

  initial begin
    for (int r = 0; r < 10; r++) begin
      msize[r] = 0;
      for (int c = 0; c < 24; c++) begin mcode[r][c] = 0; mcolor[r][c] = 0; end
    end
    repeat (3) @(negedge clk_i);
    check("R1", {red_o, green_o, blue_o, fblank_o}, 0);
    rst_ni = 1'b1;
    step();
    check("R1", {red_o, green_o, blue_o, fblank_o}, 0);

    // rows 0..8 filled; row 9 left at reset contents (R1)
    for (int r = 0; r < 9; r++)
      for (int c = 0; c < 24; c++)
        put_cell(r, c, ((r + c) % 7 == 0) ? 0 : (r * 24 + c * 5 + 1) % 128, (r + c) % 8);
    put_cell(0, 30, 7'h55, 7);   // R10: would alias row 1 col 6 if not dropped
    put_cell(12, 2, 7'h2a, 5);
    put_size(1, 2);
    put_size(2, 1);
    put_size(3, 3);
    put_size(11, 3);             // R10: out of range size write

    h_origin_i = 11'd10;
    v_origin_i = 10'd3;
    frame(120, 600, -1, 0);

    put_size(1, 0);
    put_size(2, 0);
    put_size(3, 0);
    h_origin_i = 11'd20;
    v_origin_i = 10'd2;
    frame(168, 320, 50, 150);    // line 50 cut short by an early sync (R2)

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end
endmodule